// File: doc/BRIEF.md
# Programmable Tap Divider Timer

This block is a long binary divider with a selectable output tap, built as one synchronous counter driven from the system clock. Each enabled clock advances the chain by one. A hold input freezes it. Two control inputs force every stage to zero or to one. A skip input leaves the lowest section of the chain idle, so the upper two sections count the input clock directly. A select code picks one bit from the upper two sections and routes it to a single output.

The chain has three sections of `SECT` stages each. The default is 8 stages per section, which gives 24 stages and 16 selectable taps. Driving skip, clear and fill high together puts the chain into a split test mode. In that mode each section counts the input clock on its own.

An optional pulse stretcher sits after the tap mux. When it is enabled, each rising edge of the selected bit produces a pulse whose length in clocks comes from a width input. An edge that arrives while a pulse is still running is dropped.

Top module: `prog_tap_timer`

## Requirements
- R1: While the system reset is low, and once it is released, every stage reads 0 and `tap_out` is 0.
- R2: In full mode (skip, clear and fill low, hold low), `count_q` increases by 1 on each clock and wraps from all ones to 0 over `3*SECT` bits.
- R3: While `hold` is 1 and neither `clr` nor `fill` is 1, `count_q` does not change.
- R4: Outside split mode, `clr` = 1 makes `count_q` 0 on the next clock. This takes priority over `fill` and over `hold`.
- R5: With `fill` = 1 and `clr` = 0 (outside split mode), `count_q` becomes all ones on the next clock.
- R6: With `skip_low` = 1 (outside split mode and with no load), bits `[SECT-1:0]` keep their value. The upper `2*SECT` bits, read as one number, increase by 1 on each clock that is not held.
- R7: With `skip_low`, `clr` and `fill` all 1 (split mode), each `SECT`-bit section increases by 1 modulo `2^SECT` on every clock with no carry between sections. `hold` still freezes all three.
- R8: With `pulse_en` = 0, `tap_out` equals `count_q[SECT + tap_sel]`. Code 0 selects the lowest stage of the middle section, and the highest code selects the top stage. `skip_low` does not change this mapping.
- R9: With `pulse_en` = 1 and `pulse_len` = N > 0, a rising edge of the selected bit is registered one clock later. `tap_out` then goes high for exactly N clocks, starting one clock after the selected bit rises. While no pulse is running, `tap_out` is 0.
- R10: With `pulse_en` = 1, a rising edge of the selected bit while a pulse is running starts no new pulse. With `pulse_len` = 0, no pulse starts and `tap_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for the divider and the pulse stretcher |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| skip_low | input | 1 | Leaves the lowest section idle so the input clock drives the middle section |
| clr | input | 1 | Forces all stages to 0 on the next clock |
| fill | input | 1 | Forces all stages to 1 on the next clock |
| hold | input | 1 | Clock inhibit: stops the counter from advancing |
| tap_sel | input | $clog2(2*SECT) | Index of the upper-section stage routed to the output |
| pulse_en | input | 1 | Routes the pulse stretcher instead of the raw tap to the output |
| pulse_len | input | LEN_W | Pulse length in clocks |
| tap_out | output | 1 | Decoded output: raw tap bit or stretched pulse |
| count_q | output | 3*SECT | Current state of all divider stages |

## Verification
The bench builds the block with `SECT` = 2 and `LEN_W` = 3. That gives a 6-stage chain, four taps and a 2-bit select code, so the whole 64-state cycle of full mode can be walked and its wrap seen several times. With 2-bit sections, split mode wraps each section every four clocks, and skip mode wraps the upper field every sixteen. Every select code and every pulse length from 0 to 7 is swept. The pulse test runs against a slow tap, where edges are widely spaced, and against a fast tap, where new edges keep landing inside a running pulse.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    CHAIN_FULL  = 2'd0,
    CHAIN_SKIP  = 2'd1,
    CHAIN_SPLIT = 2'd2
  } chain_mode_e;

  // Split mode needs all three controls; skip alone removes the low section.
  function automatic chain_mode_e pick_mode(input logic skip, input logic clr, input logic fill);
    if (skip && clr && fill) return CHAIN_SPLIT;
    if (skip)                return CHAIN_SKIP;
    return CHAIN_FULL;
  endfunction

endpackage

// File: rtl/timer_chain.sv
module timer_chain
  import timer_pkg::*;
#(
  parameter  int SECT   = 8,
  localparam int STAGES = 3 * SECT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chain_mode_e       mode,
  input  logic              adv,
  input  logic              load_zero,
  input  logic              load_ones,
  output logic [STAGES-1:0] q
);

  logic [STAGES-1:0] q_r;
  logic [STAGES-1:0] q_nxt;
  logic [STAGES-1:0] run_v;

  // Toggle enables: a stage runs when all lower stages of its section are 1.
  // A section head takes the raw advance when the mode cuts the chain there.
  always_comb begin : carry_p
    logic run;
    logic prev_q;
    run    = 1'b0;
    prev_q = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      if (k == 0)
        run = adv && (mode != CHAIN_SKIP);
      else if ((k == SECT) && (mode != CHAIN_FULL))
        run = adv;
      else if ((k == 2 * SECT) && (mode == CHAIN_SPLIT))
        run = adv;
      else
        run = run && prev_q;
      run_v[k] = run;
      prev_q   = q_r[k];
    end
  end

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      assign q_nxt[k] = load_zero ? 1'b0 :
                        load_ones ? 1'b1 :
                        (q_r[k] ^ run_v[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/timer_tap_mux.sv
module timer_tap_mux #(
  parameter  int SECT   = 8,
  localparam int STAGES = 3 * SECT,
  localparam int TAPS   = 2 * SECT,
  localparam int SEL_W  = $clog2(TAPS)
) (
  input  logic [STAGES-1:0] q,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap
);

  logic [TAPS-1:0] taps;

  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_tap
      assign taps[i] = q[SECT + i];
    end
  endgenerate

  assign tap = taps[sel];

endmodule

// File: rtl/timer_oneshot.sv
module timer_oneshot #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] len,
  input  logic             tap,
  output logic             pulse
);

  logic             tap_d;
  logic [LEN_W-1:0] left_r;
  logic [LEN_W-1:0] left_nxt;
  logic             rise;

  assign rise = tap && !tap_d;

  // A running pulse ignores new edges; a zero length never starts one.
  always_comb begin
    if (left_r != '0)
      left_nxt = left_r - 1'b1;
    else if (enable && rise)
      left_nxt = len;
    else
      left_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_d  <= 1'b0;
      left_r <= '0;
    end else begin
      tap_d  <= tap;
      left_r <= left_nxt;
    end
  end

  assign pulse = (left_r != '0);

endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer
  import timer_pkg::*;
#(
  parameter  int SECT   = 8,
  parameter  int LEN_W  = 8,
  localparam int STAGES = 3 * SECT,
  localparam int SEL_W  = $clog2(2 * SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              skip_low,
  input  logic              clr,
  input  logic              fill,
  input  logic              hold,
  input  logic [SEL_W-1:0]  tap_sel,
  input  logic              pulse_en,
  input  logic [LEN_W-1:0]  pulse_len,
  output logic              tap_out,
  output logic [STAGES-1:0] count_q
);

  logic        rst_meta_n;
  logic        rst_core_n;
  chain_mode_e mode;
  logic        split;
  logic        load_zero;
  logic        load_ones;
  logic        adv;
  logic        tap_raw;
  logic        pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  assign mode      = pick_mode(skip_low, clr, fill);
  assign split     = (mode == CHAIN_SPLIT);
  assign load_zero = clr && !split;
  assign load_ones = fill && !clr && !split;
  assign adv       = !hold;

  timer_chain #(.SECT(SECT)) u_chain (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .mode      (mode),
    .adv       (adv),
    .load_zero (load_zero),
    .load_ones (load_ones),
    .q         (count_q)
  );

  timer_tap_mux #(.SECT(SECT)) u_mux (
    .q   (count_q),
    .sel (tap_sel),
    .tap (tap_raw)
  );

  timer_oneshot #(.LEN_W(LEN_W)) u_shot (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .enable (pulse_en),
    .len    (pulse_len),
    .tap    (tap_raw),
    .pulse  (pulse)
  );

  assign tap_out = pulse_en ? pulse : tap_raw;

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter  int SECT   = 8,
  parameter  int LEN_W  = 8,
  localparam int STAGES = 3 * SECT,
  localparam int SEL_W  = $clog2(2 * SECT)
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              skip_low,
  input logic              clr,
  input logic              fill,
  input logic              hold,
  input logic [SEL_W-1:0]  tap_sel,
  input logic              pulse_en,
  input logic [LEN_W-1:0]  pulse_len,
  input logic              tap_out,
  input logic [STAGES-1:0] count_q
);

  logic split_m;
  assign split_m = skip_low && clr && fill;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!hold && !clr && !fill && !skip_low) |=> (count_q == STAGES'($past(count_q) + 1'b1))); // R2

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hold && !clr && !fill) |=> $stable(count_q)); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (clr && !split_m) |=> (count_q == '0)); // R4

  AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fill && !clr) |=> (&count_q)); // R5

  AST_SKIP_LOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (skip_low && !clr && !fill) |=> $stable(count_q[SECT-1:0])); // R6

  AST_SPLIT_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (split_m && !hold) |=> (count_q[SECT-1:0] == SECT'($past(count_q[SECT-1:0]) + 1'b1))); // R7

  AST_TAP_DIRECT: assert property (@(posedge clk) disable iff (!rst_core_n)
    !pulse_en |-> (tap_out == count_q[SECT + int'(tap_sel)])); // R8

  AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pulse_en && (pulse_len == '0) && !tap_out) |=> (!pulse_en || !tap_out)); // R10

endmodule

bind prog_tap_timer timer_chk #(.SECT(SECT), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .skip_low   (skip_low),
  .clr        (clr),
  .fill       (fill),
  .hold       (hold),
  .tap_sel    (tap_sel),
  .pulse_en   (pulse_en),
  .pulse_len  (pulse_len),
  .tap_out    (tap_out),
  .count_q    (count_q)
);

// File: tb/tb_prog_tap_timer.sv
`timescale 1ns/1ps
module tb_prog_tap_timer;

  localparam int SECT   = 2;
  localparam int LEN_W  = 3;
  localparam int STAGES = 3 * SECT;
  localparam int SEL_W  = $clog2(2 * SECT);
  localparam int SMASK  = (1 << SECT) - 1;
  localparam int UMASK  = (1 << (2 * SECT)) - 1;
  localparam int AMASK  = (1 << STAGES) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              skip_low, clr, fill, hold, pulse_en;
  logic [SEL_W-1:0]  tap_sel;
  logic [LEN_W-1:0]  pulse_len;
  logic              tap_out;
  logic [STAGES-1:0] count_q;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int m_cnt  = 0;
  int m_left = 0;
  bit m_tapd = 1'b0;

  always #2 clk = ~clk;

  prog_tap_timer #(.SECT(SECT), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .skip_low(skip_low), .clr(clr), .fill(fill),
    .hold(hold), .tap_sel(tap_sel), .pulse_en(pulse_en), .pulse_len(pulse_len),
    .tap_out(tap_out), .count_q(count_q)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic int next_count(input int c);
    int r;
    if (skip_low && clr && fill) begin
      if (hold) return c;
      r = 0;
      for (int s = 0; s < 3; s++)
        r |= ((((c >> (s * SECT)) & SMASK) + 1) & SMASK) << (s * SECT);
      return r;
    end
    if (clr)  return 0;
    if (fill) return AMASK;
    if (hold) return c;
    if (skip_low)
      return (c & SMASK) | (((((c >> SECT) & UMASK) + 1) & UMASK) << SECT);
    return (c + 1) & AMASK;
  endfunction

  // One clock: advance the model from current inputs, then sample at the falling edge.
  task automatic tick(input string cnt_req, input string tap_req);
    bit tap_now;
    int exp_tap;
    tap_now = ((m_cnt >> (SECT + int'(tap_sel))) & 1) != 0;
    if (m_left != 0)                                m_left = m_left - 1;
    else if (pulse_en && tap_now && !m_tapd)        m_left = int'(pulse_len);
    m_tapd = tap_now;
    m_cnt  = next_count(m_cnt);
    @(posedge clk);
    @(negedge clk);
    exp_tap = pulse_en ? int'(m_left != 0) : ((m_cnt >> (SECT + int'(tap_sel))) & 1);
    check(cnt_req, int'(count_q), m_cnt);
    check(tap_req, int'(tap_out), exp_tap);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; skip_low = 1'b0; clr = 1'b0; fill = 1'b0; hold = 1'b1;
    pulse_en = 1'b0; tap_sel = '0; pulse_len = '0;
    repeat (3) @(negedge clk);
    check("R1", int'(count_q), 0);
    check("R1", int'(tap_out), 0);
    rst_n = 1'b1;
    repeat (3) tick("R1", "R1");

    // R2 / R8: full-mode walk over several wraps, rotating the tap code
    hold = 1'b0;
    for (int i = 0; i < 150; i++) begin
      tap_sel = SEL_W'(i % (2 * SECT));
      tick("R2", "R8");
    end

    // R3: inhibit
    hold = 1'b1;
    repeat (8) tick("R3", "R8");

    // R5 then wrap to zero (R2)
    hold = 1'b0; fill = 1'b1;
    tick("R5", "R8");
    fill = 1'b0;
    repeat (13) tick("R2", "R8");

    // R4: clear beats fill and hold
    clr = 1'b1; fill = 1'b1; hold = 1'b1;
    tick("R4", "R8");
    clr = 1'b0; fill = 1'b0; hold = 1'b0;
    repeat (5) tick("R2", "R8");

    // R6: skip the low section, low bits nonzero
    skip_low = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tap_sel = SEL_W'((i / 3) % (2 * SECT));
      hold = (i % 11 == 10);
      tick("R6", "R8");
    end
    hold = 1'b0;
    clr = 1'b1;
    tick("R4", "R8");
    clr = 1'b0; fill = 1'b1;
    tick("R5", "R8");

    // R7: split mode, hold toggled now and then
    clr = 1'b1;
    for (int i = 0; i < 200; i++) begin
      hold = (i % 37 == 36);
      tap_sel = SEL_W'(i % (2 * SECT));
      tick("R7", "R8");
    end
    hold = 1'b0; fill = 1'b0;
    tick("R4", "R8");
    clr = 1'b0; skip_low = 1'b0;

    // R9 / R10: pulse lengths 0..7 on a slow tap
    pulse_en = 1'b1; tap_sel = '0;
    for (int n = 0; n < (1 << LEN_W); n++) begin
      pulse_len = LEN_W'(n);
      repeat (24) tick("R2", (n == 0) ? "R10" : "R9");
    end

    // R10: fast tap, edges every two clocks inside a long pulse
    skip_low = 1'b1; tap_sel = '0; pulse_len = LEN_W'(5);
    repeat (30) tick("R6", "R10");
    pulse_len = LEN_W'(0);
    repeat (12) tick("R6", "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule